// File: doc/BRIEF.md
# Paired-Core Mirrored Lookup RAM

This block holds the two lookup RAMs of an even/odd pair of processor cores. Each core reads and writes its own RAM through a private port. Every write a core makes is also sent, with the same address and data, to the RAM of its companion core. The companion decides on its own side whether to take it. Each core has a receive-enable bit. While the bit is clear, writes coming across from the companion are thrown away. While it is set, they are stored.

If both cores set their receive-enable bits, the two RAMs stay identical as writes happen. A core that has enabled reception gets a one-cycle event pulse each time a companion write lands in its RAM. A sticky flag records these events until the core clears it with a strobe.

Acceptance is decided only by the receiver. A core that halts, or writes at random, cannot disturb a companion that has not opted in. If a local write and an accepted companion write reach the same RAM in the same cycle, the local write is stored and the companion write is dropped without an event.

Top module: `mirror_lut_pair`

## Requirements
- R1: A local write stores data at its address. A read issued with `rd_en` returns that word on `rd_data` one cycle later, and `rd_data` holds its value while `rd_en` is low. After reset `rd_data` is 0.
- R2: A read in the same cycle as a local write to the same address returns the data stored before that write.
- R3: After reset the receive-enable bit of both cores is 0. A companion write leaves the receiving RAM unchanged and raises no event.
- R4: A `cfg_set` strobe loads the receive-enable bit from bit 0 of `cfg_word`, and all other bits of the word are ignored. The new value governs companion writes from the next cycle on.
- R5: With the receive-enable bit at 1, each write by the companion is stored in the receiving RAM at the same address with the same data, so both RAMs hold the same word.
- R6: After the receive-enable bit is loaded back to 0, companion writes are again ignored and raise no event.
- R7: When a local write and an accepted companion write hit the same RAM in one cycle, the local data is stored, the companion write is dropped, and no event is raised for that cycle.
- R8: `evt` of the receiving core is high for exactly the one cycle after each applied companion write, so back-to-back writes give back-to-back pulses.
- R9: `evt_flag` goes to 1 in the cycle after an `evt` pulse and stays at 1 until an `evt_clr` strobe, which clears it in the next cycle. A pulse in the same cycle as the strobe keeps the flag set.
- R10: The enable bits are independent. Enabling reception on one core does not make the other core accept writes.
- R11: The whole range of addresses 0x000 to 0x1FF is usable, including both end addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 2 | Per-core write strobe (index 0 = even core, 1 = odd core) |
| wr_addr | input | 2x9 | Per-core write address |
| wr_data | input | 2x32 | Per-core write data |
| rd_en | input | 2 | Per-core read strobe |
| rd_addr | input | 2x9 | Per-core read address |
| rd_data | output | 2x32 | Per-core read data, one cycle after `rd_en` |
| cfg_set | input | 2 | Per-core strobe that loads the receive-enable bit |
| cfg_word | input | 2x32 | Per-core configuration operand; only bit 0 is used |
| evt | output | 2 | Per-core pulse: a companion write was applied |
| evt_clr | input | 2 | Per-core strobe that clears the sticky flag |
| evt_flag | output | 2 | Per-core sticky record of `evt` |

## Verification
The bench goes after the same-cycle collision, where both cores write one address. A design that let the forwarded write win would corrupt the local word, and one that did not drop the forwarded write would raise a spurious event. It checks that an operand with every bit set except bit 0 leaves sharing off, which catches a design that decodes the wrong bit. It also checks that a disabled or never-enabled receiver keeps its old word, which a design that gates at the sender would break. It drives a flag clear in the same cycle as an event pulse, to catch clear-wins logic, and checks read-old-data on a same-address read and write.

// File: rtl/mlut_pkg.sv
package mlut_pkg;
  localparam int unsigned LUT_WORDS = 512;
  localparam int unsigned LUT_BITS  = 32;

  typedef enum logic [1:0] {
    WSRC_NONE   = 2'd0,
    WSRC_LOCAL  = 2'd1,
    WSRC_REMOTE = 2'd2
  } wr_src_e;
endpackage

// File: rtl/lut_ram.sv
module lut_ram #(
  parameter int unsigned WORDS = 512,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [WORDS];
  logic [WIDTH-1:0] rdata_n;

  // storage array: no reset, write enable explicit
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // read path: old contents are seen on a same-cycle write
  always_comb begin
    rdata_n = rdata;
    if (re) begin
      rdata_n = mem[raddr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= rdata_n;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata)); // R1
endmodule

// File: rtl/lut_wr_arb.sv
module lut_wr_arb
  import mlut_pkg::*;
#(
  parameter int unsigned WORDS = 512,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_set,
  input  logic             cfg_bit,
  input  logic             loc_we,
  input  logic [AW-1:0]    loc_addr,
  input  logic [WIDTH-1:0] loc_data,
  input  logic             peer_we,
  input  logic [AW-1:0]    peer_addr,
  input  logic [WIDTH-1:0] peer_data,
  output logic             ram_we,
  output logic [AW-1:0]    ram_addr,
  output logic [WIDTH-1:0] ram_data,
  output logic             remote_hit,
  output logic             rx_en
);
  wr_src_e src;
  logic    rx_en_n;

  // receive-enable register: next state, then register
  always_comb begin
    rx_en_n = rx_en;
    if (cfg_set) begin
      rx_en_n = cfg_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en <= 1'b0;
    end else if (cfg_set) begin
      rx_en <= rx_en_n;
    end
  end

  // source select: local always first, remote only when accepted
  always_comb begin
    if (loc_we) begin
      src = WSRC_LOCAL;
    end else if (peer_we && rx_en) begin
      src = WSRC_REMOTE;
    end else begin
      src = WSRC_NONE;
    end
  end

  always_comb begin
    ram_we     = 1'b0;
    ram_addr   = loc_addr;
    ram_data   = loc_data;
    remote_hit = 1'b0;
    unique case (src)
      WSRC_LOCAL: begin
        ram_we = 1'b1;
      end
      WSRC_REMOTE: begin
        ram_we     = 1'b1;
        ram_addr   = peer_addr;
        ram_data   = peer_data;
        remote_hit = 1'b1;
      end
      default: begin
        ram_we = 1'b0;
      end
    endcase
  end

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_set |=> (rx_en == $past(cfg_bit))); // R4
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_set |=> $stable(rx_en)); // R6
  AST_LOCAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    loc_we |-> (ram_we && ram_addr == loc_addr && ram_data == loc_data && !remote_hit)); // R7
endmodule

// File: rtl/lut_evt.sv
module lut_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  output logic evt,
  output logic flag
);
  logic flag_n;

  always_comb begin
    flag_n = (flag & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt  <= 1'b0;
      flag <= 1'b0;
    end else begin
      evt  <= hit;
      flag <= flag_n;
    end
  end

  AST_EVT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> evt); // R8
  AST_EVT_ONLY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !evt); // R8
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag); // R9
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag); // R9
endmodule

// File: rtl/mirror_lut_pair.sv
module mirror_lut_pair
  import mlut_pkg::*;
#(
  parameter int unsigned WORDS = LUT_WORDS,
  parameter int unsigned WIDTH = LUT_BITS,
  localparam int unsigned AW   = $clog2(WORDS),
  localparam int unsigned NC   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NC-1:0]             wr_en,
  input  logic [NC-1:0][AW-1:0]     wr_addr,
  input  logic [NC-1:0][WIDTH-1:0]  wr_data,
  input  logic [NC-1:0]             rd_en,
  input  logic [NC-1:0][AW-1:0]     rd_addr,
  output logic [NC-1:0][WIDTH-1:0]  rd_data,
  input  logic [NC-1:0]             cfg_set,
  input  logic [NC-1:0][WIDTH-1:0]  cfg_word,
  output logic [NC-1:0]             evt,
  input  logic [NC-1:0]             evt_clr,
  output logic [NC-1:0]             evt_flag
);
  logic [NC-1:0]            ram_we;
  logic [NC-1:0][AW-1:0]    ram_addr;
  logic [NC-1:0][WIDTH-1:0] ram_data;
  logic [NC-1:0]            hit;
  logic [NC-1:0]            rx_en;
  logic                     unused_cfg_hi;

  // only bit 0 of the operand matters
  assign unused_cfg_hi = ^{cfg_word[0][WIDTH-1:1], cfg_word[1][WIDTH-1:1]};

  for (genvar g = 0; g < NC; g++) begin : g_core
    localparam int unsigned PEER = g ^ 1;

    lut_wr_arb #(.WORDS(WORDS), .WIDTH(WIDTH)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_set   (cfg_set[g]),
      .cfg_bit   (cfg_word[g][0]),
      .loc_we    (wr_en[g]),
      .loc_addr  (wr_addr[g]),
      .loc_data  (wr_data[g]),
      .peer_we   (wr_en[PEER]),
      .peer_addr (wr_addr[PEER]),
      .peer_data (wr_data[PEER]),
      .ram_we    (ram_we[g]),
      .ram_addr  (ram_addr[g]),
      .ram_data  (ram_data[g]),
      .remote_hit(hit[g]),
      .rx_en     (rx_en[g])
    );

    lut_ram #(.WORDS(WORDS), .WIDTH(WIDTH)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ram_we[g]),
      .waddr (ram_addr[g]),
      .wdata (ram_data[g]),
      .re    (rd_en[g]),
      .raddr (rd_addr[g]),
      .rdata (rd_data[g])
    );

    lut_evt u_evt (
      .clk  (clk),
      .rst_n(rst_n),
      .hit  (hit[g]),
      .clr  (evt_clr[g]),
      .evt  (evt[g]),
      .flag (evt_flag[g])
    );

    AST_COLLIDE_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[g] && wr_en[PEER]) |=> !evt[g]); // R7
    AST_REJECT_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[PEER] && !rx_en[g]) |=> !evt[g]); // R6
    AST_ACCEPT_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[PEER] && rx_en[g] && !wr_en[g]) |=> evt[g]); // R5
  end
endmodule

// File: tb/mirror_lut_pair_bench.sv
module mirror_lut_pair_bench;
  localparam int unsigned AW = 9;
  localparam int unsigned DW = 32;

  logic                clk;
  logic                rst_n;
  logic [1:0]          wr_en;
  logic [1:0][AW-1:0]  wr_addr;
  logic [1:0][DW-1:0]  wr_data;
  logic [1:0]          rd_en;
  logic [1:0][AW-1:0]  rd_addr;
  logic [1:0][DW-1:0]  rd_data;
  logic [1:0]          cfg_set;
  logic [1:0][DW-1:0]  cfg_word;
  logic [1:0]          evt;
  logic [1:0]          evt_clr;
  logic [1:0]          evt_flag;

  int checks;
  int errors;
  bit done;

  mirror_lut_pair u_mirror_lut_pair (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cfg_set(cfg_set),
    .cfg_word(cfg_word), .evt(evt), .evt_clr(evt_clr), .evt_flag(evt_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act == exp, req, act, exp);
  endtask

  // all tasks start and end at a falling edge
  task automatic do_write(input int c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en[c] = 1'b1; wr_addr[c] = a; wr_data[c] = d;
    @(negedge clk);
    wr_en[c] = 1'b0;
  endtask

  task automatic do_write2(input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                           input logic [AW-1:0] a1, input logic [DW-1:0] d1);
    wr_en = 2'b11; wr_addr[0] = a0; wr_data[0] = d0; wr_addr[1] = a1; wr_data[1] = d1;
    @(negedge clk);
    wr_en = 2'b00;
  endtask

  task automatic do_read(input int c, input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_en[c] = 1'b1; rd_addr[c] = a;
    @(posedge clk); #1;
    d = rd_data[c];
    @(negedge clk);
    rd_en[c] = 1'b0;
  endtask

  task automatic do_cfg(input int c, input logic [DW-1:0] w);
    cfg_set[c] = 1'b1; cfg_word[c] = w;
    @(negedge clk);
    cfg_set[c] = 1'b0;
  endtask

  task automatic do_clr(input int c);
    evt_clr[c] = 1'b1;
    @(negedge clk);
    evt_clr[c] = 1'b0;
  endtask

  task automatic t_reset();
    chk_eq("R1 reset rd_data0", rd_data[0], 32'h0);
    chk_eq("R1 reset rd_data1", rd_data[1], 32'h0);
    chk_eq("R3 reset evt", {30'h0, evt}, 32'h0);
    chk_eq("R9 reset flag", {30'h0, evt_flag}, 32'h0);
  endtask

  task automatic t_local();
    logic [DW-1:0] d;
    do_write(0, 9'h000, 32'hA0A0_0001);
    do_write(0, 9'h1FF, 32'hA0A0_01FF);
    do_read(0, 9'h000, d);
    chk_eq("R11 addr 0x000", d, 32'hA0A0_0001);
    do_read(0, 9'h1FF, d);
    chk_eq("R11 addr 0x1FF", d, 32'hA0A0_01FF);
    rd_addr[0] = 9'h000;
    @(negedge clk);
    chk_eq("R1 rd_data holds when rd_en low", rd_data[0], 32'hA0A0_01FF);
  endtask

  task automatic t_old_data();
    logic [DW-1:0] d;
    do_write(1, 9'h040, 32'h1111_1111);
    wr_en[1] = 1'b1; wr_addr[1] = 9'h040; wr_data[1] = 32'h2222_2222;
    rd_en[1] = 1'b1; rd_addr[1] = 9'h040;
    @(posedge clk); #1;
    d = rd_data[1];
    @(negedge clk);
    wr_en[1] = 1'b0; rd_en[1] = 1'b0;
    chk_eq("R2 same-cycle read gives old data", d, 32'h1111_1111);
    do_read(1, 9'h040, d);
    chk_eq("R2 later read gives new data", d, 32'h2222_2222);
  endtask

  task automatic t_default_ignore();
    logic [DW-1:0] d;
    do_write(1, 9'h005, 32'hBBBB_0005);
    do_write(0, 9'h005, 32'hCCCC_0005);
    chk_eq("R3 no event while disabled", {31'h0, evt[1]}, 32'h0);
    do_read(1, 9'h005, d);
    chk_eq("R3 companion write ignored after reset", d, 32'hBBBB_0005);
  endtask

  task automatic t_enable_share();
    logic [DW-1:0] d;
    do_cfg(1, 32'hFFFF_FFFE);
    do_write(1, 9'h007, 32'h0000_7777);
    do_write(0, 9'h007, 32'hDEAD_0007);
    chk_eq("R4 operand bit0=0 keeps sharing off (evt)", {31'h0, evt[1]}, 32'h0);
    do_read(1, 9'h007, d);
    chk_eq("R4 operand bit0=0 keeps sharing off (data)", d, 32'h0000_7777);
    do_cfg(1, 32'h0000_0001);
    do_write(0, 9'h007, 32'hFACE_0007);
    chk_eq("R8 evt high cycle after write", {31'h0, evt[1]}, 32'h1);
    @(negedge clk);
    chk_eq("R8 evt lasts one cycle", {31'h0, evt[1]}, 32'h0);
    chk_eq("R9 flag set after pulse", {31'h0, evt_flag[1]}, 32'h1);
    do_read(1, 9'h007, d);
    chk_eq("R5 companion data mirrored", d, 32'hFACE_0007);
    do_read(0, 9'h007, d);
    chk_eq("R5 local copy matches", d, 32'hFACE_0007);
    chk_eq("R9 flag stays set", {31'h0, evt_flag[1]}, 32'h1);
    do_clr(1);
    chk_eq("R9 flag cleared by strobe", {31'h0, evt_flag[1]}, 32'h0);
    do_write(0, 9'h010, 32'h0000_0010);
    do_write(0, 9'h011, 32'h0000_0011);
    chk_eq("R8 back-to-back second pulse", {31'h0, evt[1]}, 32'h1);
    @(negedge clk);
    chk_eq("R8 pulses end", {31'h0, evt[1]}, 32'h0);
    do_clr(1);
    do_write(0, 9'h012, 32'h0000_0012);
    do_clr(1);
    chk_eq("R9 pulse during clear keeps flag", {31'h0, evt_flag[1]}, 32'h1);
    do_clr(1);
    // independence: core0 still not enabled
    do_write(0, 9'h020, 32'h0000_A020);
    do_write(1, 9'h020, 32'h0000_B020);
    chk_eq("R10 core0 no event while only core1 enabled", {31'h0, evt[0]}, 32'h0);
    do_read(0, 9'h020, d);
    chk_eq("R10 core0 keeps own data", d, 32'h0000_A020);
  endtask

  task automatic t_collision();
    logic [DW-1:0] d;
    do_cfg(0, 32'h0000_0003);
    do_write2(9'h030, 32'h0A0A_0030, 9'h030, 32'h0B0B_0030);
    chk_eq("R7 no event core0 on collision", {31'h0, evt[0]}, 32'h0);
    chk_eq("R7 no event core1 on collision", {31'h0, evt[1]}, 32'h0);
    do_read(0, 9'h030, d);
    chk_eq("R7 core0 keeps local data", d, 32'h0A0A_0030);
    do_read(1, 9'h030, d);
    chk_eq("R7 core1 keeps local data", d, 32'h0B0B_0030);
    do_write(1, 9'h031, 32'h0C0C_0031);
    chk_eq("R5 core0 event after enabling", {31'h0, evt[0]}, 32'h1);
    do_read(0, 9'h031, d);
    chk_eq("R5 core0 receives companion data", d, 32'h0C0C_0031);
  endtask

  task automatic t_disable();
    logic [DW-1:0] d;
    do_write(1, 9'h050, 32'h5050_0001);
    do_cfg(1, 32'h8000_0000);
    @(negedge clk);
    do_write(0, 9'h050, 32'h5050_0002);
    chk_eq("R6 no event after disable", {31'h0, evt[1]}, 32'h0);
    do_read(1, 9'h050, d);
    chk_eq("R6 companion write ignored after disable", d, 32'h5050_0001);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    wr_en = '0; wr_addr = '0; wr_data = '0; rd_en = '0; rd_addr = '0;
    cfg_set = '0; cfg_word = '0; evt_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_local();
    t_old_data();
    t_default_ignore();
    t_enable_share();
    t_collision();
    t_disable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule